// File: doc/BRIEF.md
# Reservation Station Queue with Result-Bus Snooping

This block keeps the pending instructions for one function unit in a short ordered queue. An instruction arrives from the issue stage with its op bits, its reorder-buffer tag and six operand records. Each record holds a producer tag, a valid bit and a 32-bit data word. The first and second operands each have a low part and a high part. The third and fourth operands are single integer words. A new instruction always enters the youngest end of the queue. Every cycle, older entries move one place toward the oldest end whenever a vacancy lies at or beyond their position, so the queue stays in age order.

Every operand record that is still waiting compares its producer tag with the tag on the common data bus (CDB). On a match it takes its lane of the bus. The captured operand counts as valid in the same cycle, so an instruction whose last operand arrives on the bus can be handed to the function unit at once, carrying the bus value. A record also captures while it moves between entries, and while it sits on the issue port in the cycle the queue accepts it.

In any cycle, any entry whose operands are all present may be sent out, not only the oldest one. When several entries qualify, the oldest is presented. Both edges of the block use valid/ready. The queue refuses issue only when every entry is occupied and none of them leaves in that cycle. `iss_ready` may therefore depend combinationally on `dsp_ready`. Once `dsp_valid` is high, it stays high until a transfer happens. The presented entry may still change to an older one that has just become ready.

Top module: `rs_queue`

## Requirements
- R1: After reset, every entry is empty: `dsp_valid` is 0 and `iss_ready` is 1.
- R2: `iss_ready` is 0 only when all DEPTH entries are occupied and no dispatch transfer (`dsp_valid && dsp_ready`) takes place in that cycle. An instruction is taken when `iss_valid && iss_ready`.
- R3: An operand record that is not valid captures the bus when `cdb_valid` is 1 and `cdb_tag` equals its tag, and it becomes valid. Slot numbering is 0 = first operand low, 1 = first operand high, 2 = second operand low, 3 = second operand high, 4 = third operand, 5 = fourth operand. Slots 1 and 3 take `cdb_data[63:32]`; the other slots take `cdb_data[31:0]`. Capture also happens for a record on the issue port in the cycle it is accepted, and for a record moving between entries.
- R4: An operand record that is already valid keeps its data when the bus carries a matching tag.
- R5: An entry whose last missing operand is captured in a cycle is eligible for dispatch in that same cycle, and `dsp_data` then carries the captured bus value.
- R6: When several entries are ready, the one accepted earliest is presented on `dsp_*`.
- R7: A younger ready entry is dispatched while older entries still wait for operands.
- R8: While `dsp_ready` is 0, no entry leaves. Once asserted, `dsp_valid` stays 1 until a transfer.
- R9: Every accepted instruction is dispatched exactly once, with its op bits, ROB tag and operand data intact, and ready entries leave in age order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue stage offers an instruction |
| iss_ready | output | 1 | Queue accepts the offered instruction |
| iss_op | input | OPB_W | Operation bits for the function unit |
| iss_tag | input | TAG_W | ROB tag of the instruction |
| iss_opnd_tag | input | 6*TAG_W | Producer tag per operand slot (slot s at bits s*TAG_W) |
| iss_opnd_vld | input | 6 | Valid bit per operand slot; unused slots are issued valid |
| iss_opnd_data | input | 6*DATA_W | Data per operand slot |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | ROB tag of the result |
| cdb_data | input | 2*DATA_W | Result; high half at the top |
| dsp_valid | output | 1 | A ready entry is presented |
| dsp_ready | input | 1 | Function unit takes the presented entry |
| dsp_op | output | OPB_W | Op bits of the presented entry |
| dsp_tag | output | TAG_W | ROB tag of the presented entry |
| dsp_data | output | 6*DATA_W | Operand data of the presented entry, slot s at bits s*DATA_W |

## Verification
Two kinds of same-cycle coincidence matter most. The first is a bus capture and a dispatch of the same entry, which happens when its last operand arrives. The second is an issue into a full queue in the cycle an entry leaves. The directed cases force each of them: one holds an entry with a single missing operand and then drives the matching tag with `dsp_ready` high; another fills the queue, offers one more instruction, and releases all waiting entries with one bus result. A constrained-random phase uses a small tag space, so captures, shifts, issues and dispatches overlap often. An age-ordered bench model computes, for every cycle, the expected `iss_ready`, `dsp_valid` and presented contents.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  localparam int NUM_SLOT = 6;

  // Slots 1 and 3 hold high halves of the two wide operands.
  function automatic bit slot_is_hi(input int s);
    return (s == 1) || (s == 3);
  endfunction
endpackage

// File: rtl/rsq_snoop.sv
module rsq_snoop #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic [TAG_W-1:0]  rec_tag,
  input  logic              rec_vld,
  input  logic [DATA_W-1:0] rec_data,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] lane_data,
  output logic              upd_vld,
  output logic [DATA_W-1:0] upd_data
);
  logic grab;

  assign grab     = cdb_valid & ~rec_vld & (cdb_tag == rec_tag);
  assign upd_vld  = rec_vld | grab;
  assign upd_data = grab ? lane_data : rec_data;
endmodule

// File: rtl/rsq_entry.sv
module rsq_entry #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int OPB_W  = 9,
  localparam int NS    = rsq_pkg::NUM_SLOT,
  localparam int REC_W = TAG_W + 1 + DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift,
  input  logic                src_keep,
  input  logic [OPB_W-1:0]    src_op,
  input  logic [TAG_W-1:0]    src_tag,
  input  logic [NS*REC_W-1:0] src_recs,
  input  logic                cdb_valid,
  input  logic [TAG_W-1:0]    cdb_tag,
  input  logic [2*DATA_W-1:0] cdb_data,
  output logic                full,
  output logic [OPB_W-1:0]    op,
  output logic [TAG_W-1:0]    tag,
  output logic [NS*REC_W-1:0] upd_recs,
  output logic                rdy
);
  logic                full_q;
  logic [OPB_W-1:0]    op_q;
  logic [TAG_W-1:0]    tag_q;
  logic [NS*REC_W-1:0] recs_q;
  logic [NS-1:0]       vld_vec;

  for (genvar s = 0; s < NS; s++) begin : g_slot
    localparam bit HI = rsq_pkg::slot_is_hi(s);
    logic [REC_W-1:0]  cur;
    logic [DATA_W-1:0] lane;
    logic              s_vld;
    logic [DATA_W-1:0] s_dat;

    assign cur  = recs_q[s*REC_W +: REC_W];
    assign lane = HI ? cdb_data[2*DATA_W-1:DATA_W] : cdb_data[DATA_W-1:0];

    rsq_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snp (
      .rec_tag   (cur[REC_W-1 -: TAG_W]),
      .rec_vld   (cur[DATA_W]),
      .rec_data  (cur[DATA_W-1:0]),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .lane_data (lane),
      .upd_vld   (s_vld),
      .upd_data  (s_dat)
    );

    assign upd_recs[s*REC_W +: REC_W] = {cur[REC_W-1 -: TAG_W], s_vld, s_dat};
    assign vld_vec[s] = s_vld;
  end

  assign full = full_q;
  assign op   = op_q;
  assign tag  = tag_q;
  assign rdy  = full_q & (&vld_vec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      op_q   <= '0;
      tag_q  <= '0;
      recs_q <= '0;
    end else if (shift) begin
      full_q <= src_keep;
      op_q   <= src_op;
      tag_q  <= src_tag;
      recs_q <= src_recs;
    end else begin
      recs_q <= upd_recs;
    end
  end
endmodule

// File: rtl/rsq_pick.sv
module rsq_pick #(
  parameter int DEPTH = 4
) (
  input  logic [DEPTH-1:0] rdy,
  output logic             any,
  output logic [DEPTH-1:0] sel
);
  // Highest index is the oldest entry and wins.
  always_comb begin
    sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rdy[i]) begin
        sel    = '0;
        sel[i] = 1'b1;
      end
    end
  end

  assign any = |rdy;
endmodule

// File: rtl/rs_queue.sv
module rs_queue #(
  parameter int DEPTH  = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 32,
  parameter int OPB_W  = 9
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                iss_valid,
  output logic                                iss_ready,
  input  logic [OPB_W-1:0]                    iss_op,
  input  logic [TAG_W-1:0]                    iss_tag,
  input  logic [rsq_pkg::NUM_SLOT*TAG_W-1:0]  iss_opnd_tag,
  input  logic [rsq_pkg::NUM_SLOT-1:0]        iss_opnd_vld,
  input  logic [rsq_pkg::NUM_SLOT*DATA_W-1:0] iss_opnd_data,
  input  logic                                cdb_valid,
  input  logic [TAG_W-1:0]                    cdb_tag,
  input  logic [2*DATA_W-1:0]                 cdb_data,
  output logic                                dsp_valid,
  input  logic                                dsp_ready,
  output logic [OPB_W-1:0]                    dsp_op,
  output logic [TAG_W-1:0]                    dsp_tag,
  output logic [rsq_pkg::NUM_SLOT*DATA_W-1:0] dsp_data
);
  localparam int NS    = rsq_pkg::NUM_SLOT;
  localparam int REC_W = TAG_W + 1 + DATA_W;

  logic [NS*REC_W-1:0] iss_recs;
  logic [DEPTH-1:0]    full, rdy, sel, doe, free, keep, src_keep;
  logic [OPB_W-1:0]    ent_op   [DEPTH];
  logic [TAG_W-1:0]    ent_tag  [DEPTH];
  logic [NS*REC_W-1:0] ent_recs [DEPTH];
  logic [OPB_W-1:0]    src_op   [DEPTH];
  logic [TAG_W-1:0]    src_tag  [DEPTH];
  logic [NS*REC_W-1:0] src_recs [DEPTH];
  logic                fire;

  // Issue-port records snoop too, so a result in the accept cycle is kept.
  for (genvar s = 0; s < NS; s++) begin : g_iss
    localparam bit HI = rsq_pkg::slot_is_hi(s);
    logic [DATA_W-1:0] lane;
    logic              s_vld;
    logic [DATA_W-1:0] s_dat;

    assign lane = HI ? cdb_data[2*DATA_W-1:DATA_W] : cdb_data[DATA_W-1:0];

    rsq_snoop #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snp (
      .rec_tag   (iss_opnd_tag[s*TAG_W +: TAG_W]),
      .rec_vld   (iss_opnd_vld[s]),
      .rec_data  (iss_opnd_data[s*DATA_W +: DATA_W]),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .lane_data (lane),
      .upd_vld   (s_vld),
      .upd_data  (s_dat)
    );

    assign iss_recs[s*REC_W +: REC_W] = {iss_opnd_tag[s*TAG_W +: TAG_W], s_vld, s_dat};
  end

  // Entry 0 is the youngest position, entry DEPTH-1 the oldest.
  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    if (i == 0) begin : g_head_in
      assign src_keep[i] = iss_valid;
      assign src_op[i]   = iss_op;
      assign src_tag[i]  = iss_tag;
      assign src_recs[i] = iss_recs;
    end else begin : g_chain
      assign src_keep[i] = keep[i-1];
      assign src_op[i]   = ent_op[i-1];
      assign src_tag[i]  = ent_tag[i-1];
      assign src_recs[i] = ent_recs[i-1];
    end

    rsq_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OPB_W(OPB_W)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift     (free[i]),
      .src_keep  (src_keep[i]),
      .src_op    (src_op[i]),
      .src_tag   (src_tag[i]),
      .src_recs  (src_recs[i]),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_data  (cdb_data),
      .full      (full[i]),
      .op        (ent_op[i]),
      .tag       (ent_tag[i]),
      .upd_recs  (ent_recs[i]),
      .rdy       (rdy[i])
    );
  end

  rsq_pick #(.DEPTH(DEPTH)) u_pick (
    .rdy (rdy),
    .any (dsp_valid),
    .sel (sel)
  );

  assign fire = dsp_valid & dsp_ready;
  assign doe  = sel & {DEPTH{fire}};
  assign keep = full & ~doe;

  // An entry shifts when a vacancy exists at it or anywhere older.
  always_comb begin
    logic carry;
    carry = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      free[i] = ~full[i] | doe[i] | carry;
      carry   = free[i];
    end
  end

  assign iss_ready = free[0];

  always_comb begin
    dsp_op   = '0;
    dsp_tag  = '0;
    dsp_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel[i]) begin
        dsp_op  = dsp_op | ent_op[i];
        dsp_tag = dsp_tag | ent_tag[i];
        for (int s = 0; s < NS; s++) begin
          dsp_data[s*DATA_W +: DATA_W] = dsp_data[s*DATA_W +: DATA_W]
                                       | ent_recs[i][s*REC_W +: DATA_W];
        end
      end
    end
  end
endmodule

// File: rtl/rs_queue_chk.sv
module rs_queue_chk #(
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_valid,
  input logic             iss_ready,
  input logic             dsp_valid,
  input logic             dsp_ready,
  input logic [DEPTH-1:0] full,
  input logic [DEPTH-1:0] doe
);
  // R2
  refuse_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_ready |-> ((&full) && !(dsp_valid && dsp_ready)));

  // R9
  no_empty_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doe & ~full) == '0);

  // R6
  single_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(doe));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> dsp_valid);

  // R9
  occupancy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($countones(full) == $past($countones(full))
                + int'($past(iss_valid && iss_ready))
                - int'($past(dsp_valid && dsp_ready))));
endmodule

bind rs_queue rs_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_valid (iss_valid),
  .iss_ready (iss_ready),
  .dsp_valid (dsp_valid),
  .dsp_ready (dsp_ready),
  .full      (full),
  .doe       (doe)
);

// File: tb/sim_rs_queue.sv
`timescale 1ns/1ps
module sim_rs_queue;
  localparam int DEPTH = 4, TAG_W = 4, DATA_W = 32, OPB_W = 9, NS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                 iss_valid, iss_ready;
  logic [OPB_W-1:0]     iss_op;
  logic [TAG_W-1:0]     iss_tag;
  logic [NS*TAG_W-1:0]  iss_opnd_tag;
  logic [NS-1:0]        iss_opnd_vld;
  logic [NS*DATA_W-1:0] iss_opnd_data;
  logic                 cdb_valid;
  logic [TAG_W-1:0]     cdb_tag;
  logic [2*DATA_W-1:0]  cdb_data;
  logic                 dsp_valid, dsp_ready;
  logic [OPB_W-1:0]     dsp_op;
  logic [TAG_W-1:0]     dsp_tag;
  logic [NS*DATA_W-1:0] dsp_data;

  rs_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .OPB_W(OPB_W)) u0 (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_op(iss_op), .iss_tag(iss_tag), .iss_opnd_tag(iss_opnd_tag),
    .iss_opnd_vld(iss_opnd_vld), .iss_opnd_data(iss_opnd_data),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .dsp_valid(dsp_valid), .dsp_ready(dsp_ready), .dsp_op(dsp_op),
    .dsp_tag(dsp_tag), .dsp_data(dsp_data)
  );

  int    checks = 0, errors = 0;
  string cur_req = "R1";

  // Bench model, index 0 = oldest.
  int               m_cnt = 0;
  logic [OPB_W-1:0] m_op [DEPTH];
  logic [TAG_W-1:0] m_rt [DEPTH];
  logic [TAG_W-1:0] m_ot [DEPTH][NS];
  logic             m_ov [DEPTH][NS];
  logic [DATA_W-1:0] m_od [DEPTH][NS];

  function automatic logic [DATA_W-1:0] lane_of(int s);
    return ((s == 1) || (s == 3)) ? cdb_data[2*DATA_W-1:DATA_W] : cdb_data[DATA_W-1:0];
  endfunction

  function automatic logic hit_of(logic v, logic [TAG_W-1:0] t);
    return cdb_valid && !v && (t == cdb_tag);
  endfunction

  task automatic chk(string req, string what, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    logic              sv [DEPTH][NS];
    logic [DATA_W-1:0] sd [DEPTH][NS];
    logic              iv [NS];
    logic [DATA_W-1:0] id [NS];
    int                k;
    logic              exp_dv, exp_rdy, allv;
    logic [NS*DATA_W-1:0] exp_d;
    #1;
    k = -1;
    for (int e = 0; e < m_cnt; e++) begin
      allv = 1'b1;
      for (int s = 0; s < NS; s++) begin
        sv[e][s] = m_ov[e][s] | hit_of(m_ov[e][s], m_ot[e][s]);
        sd[e][s] = hit_of(m_ov[e][s], m_ot[e][s]) ? lane_of(s) : m_od[e][s];
        allv = allv & sv[e][s];
      end
      if (allv && k < 0) k = e;
    end
    for (int s = 0; s < NS; s++) begin
      iv[s] = iss_opnd_vld[s] | hit_of(iss_opnd_vld[s], iss_opnd_tag[s*TAG_W +: TAG_W]);
      id[s] = hit_of(iss_opnd_vld[s], iss_opnd_tag[s*TAG_W +: TAG_W]) ? lane_of(s)
            : iss_opnd_data[s*DATA_W +: DATA_W];
    end
    exp_dv  = (k >= 0);
    exp_rdy = (m_cnt < DEPTH) || (exp_dv && dsp_ready);
    chk("R2", "iss_ready", 256'(iss_ready), 256'(exp_rdy));
    chk(cur_req, "dsp_valid", 256'(dsp_valid), 256'(exp_dv));
    if (exp_dv) begin
      exp_d = '0;
      for (int s = 0; s < NS; s++) exp_d[s*DATA_W +: DATA_W] = sd[k][s];
      chk(cur_req, "dsp_tag", 256'(dsp_tag), 256'(m_rt[k]));
      chk(cur_req, "dsp_op", 256'(dsp_op), 256'(m_op[k]));
      chk(cur_req, "dsp_data", 256'(dsp_data), 256'(exp_d));
    end
    for (int e = 0; e < m_cnt; e++)
      for (int s = 0; s < NS; s++) begin
        m_ov[e][s] = sv[e][s];
        m_od[e][s] = sd[e][s];
      end
    if (exp_dv && dsp_ready) begin
      for (int e = k; e < m_cnt - 1; e++) begin
        m_op[e] = m_op[e+1]; m_rt[e] = m_rt[e+1];
        m_ot[e] = m_ot[e+1]; m_ov[e] = m_ov[e+1]; m_od[e] = m_od[e+1];
      end
      m_cnt--;
    end
    if (iss_valid && exp_rdy) begin
      m_op[m_cnt] = iss_op;
      m_rt[m_cnt] = iss_tag;
      for (int s = 0; s < NS; s++) begin
        m_ot[m_cnt][s] = iss_opnd_tag[s*TAG_W +: TAG_W];
        m_ov[m_cnt][s] = iv[s];
        m_od[m_cnt][s] = id[s];
      end
      m_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 1'b0;
    cdb_valid = 1'b0;
  endtask

  task automatic put(logic [TAG_W-1:0] rt, int miss, logic [TAG_W-1:0] mtag);
    iss_valid = 1'b1;
    iss_tag   = rt;
    iss_op    = OPB_W'(rt) * 9'd7 + 9'd3;
    for (int s = 0; s < NS; s++) begin
      iss_opnd_vld[s] = (s != miss);
      iss_opnd_tag[s*TAG_W +: TAG_W] = (s == miss) ? mtag : TAG_W'(s);
      iss_opnd_data[s*DATA_W +: DATA_W] = 32'hA000_0000 | (32'(rt) << 8) | 32'(s);
    end
  endtask

  task automatic bus(logic [TAG_W-1:0] t, logic [2*DATA_W-1:0] d);
    cdb_valid = 1'b1;
    cdb_tag   = t;
    cdb_data  = d;
  endtask

  task automatic drain();
    idle();
    dsp_ready = 1'b1;
    repeat (6) cycle();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    iss_valid = 0; iss_op = '0; iss_tag = '0; iss_opnd_tag = '0;
    iss_opnd_vld = '1; iss_opnd_data = '0;
    cdb_valid = 0; cdb_tag = '0; cdb_data = '0; dsp_ready = 1'b1;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    cur_req = "R1";
    repeat (2) cycle();

    // R3: high-lane capture while held
    cur_req = "R3";
    dsp_ready = 1'b0;
    put(4'd1, 1, 4'd3); cycle();
    idle(); bus(4'd3, {32'hDEAD_0001, 32'hBEEF_0001}); cycle();
    idle(); dsp_ready = 1'b1; cycle();
    drain();

    // R5: capture and dispatch in the same cycle (integer slot, low lane)
    cur_req = "R5";
    put(4'd2, 4, 4'd6); cycle();
    idle(); bus(4'd6, {32'h1234_5678, 32'h0BAD_F00D}); cycle();
    drain();

    // R3: capture on the issue port in the accept cycle
    cur_req = "R3";
    put(4'd3, 2, 4'd7); bus(4'd7, {32'h7777_0000, 32'h0000_7777}); cycle();
    idle(); cycle();
    drain();

    // R4: valid operands ignore a matching bus tag
    cur_req = "R4";
    dsp_ready = 1'b0;
    put(4'd4, -1, 4'd0);
    for (int s = 0; s < NS; s++) iss_opnd_tag[s*TAG_W +: TAG_W] = 4'd9;
    cycle();
    idle(); bus(4'd9, {32'hFFFF_FFFF, 32'hEEEE_EEEE}); cycle();
    idle(); dsp_ready = 1'b1; cycle();
    drain();

    // R6: two ready entries, oldest goes first
    cur_req = "R6";
    dsp_ready = 1'b0;
    put(4'd5, -1, 4'd0); cycle();
    put(4'd6, -1, 4'd0); cycle();
    idle(); cycle();
    dsp_ready = 1'b1; cycle(); cycle();
    drain();

    // R7: younger ready entry passes a waiting older one
    cur_req = "R7";
    dsp_ready = 1'b0;
    put(4'd7, 0, 4'd11); cycle();
    put(4'd8, -1, 4'd0); cycle();
    idle(); dsp_ready = 1'b1; cycle();
    bus(4'd11, {32'h0, 32'hCAFE_0011}); cycle();
    drain();

    // R2: full queue refuses, then accepts in the cycle one leaves
    cur_req = "R2";
    dsp_ready = 1'b0;
    for (int n = 0; n < DEPTH; n++) begin
      put(TAG_W'(9 + n), 5, 4'd12); cycle();
    end
    put(4'd13, -1, 4'd0); cycle(); cycle();
    dsp_ready = 1'b1; bus(4'd12, {32'h0, 32'h5555_AAAA}); cycle();
    drain();

    // R8: ready entry waits under back-pressure
    cur_req = "R8";
    dsp_ready = 1'b0;
    put(4'd14, -1, 4'd0); cycle();
    idle(); repeat (3) cycle();
    dsp_ready = 1'b1; cycle();
    drain();

    // R9: constrained random traffic
    cur_req = "R9";
    for (int c = 0; c < 3000; c++) begin
      iss_valid = ($urandom % 2) == 0;
      iss_tag   = TAG_W'($urandom);
      iss_op    = OPB_W'($urandom);
      for (int s = 0; s < NS; s++) begin
        iss_opnd_vld[s] = ($urandom % 2) == 0;
        iss_opnd_tag[s*TAG_W +: TAG_W] = TAG_W'($urandom % 8);
        iss_opnd_data[s*DATA_W +: DATA_W] = $urandom;
      end
      cdb_valid = ($urandom % 2) == 0;
      cdb_tag   = TAG_W'($urandom % 8);
      cdb_data  = {$urandom, $urandom};
      dsp_ready = ($urandom % 4) != 0;
      cycle();
    end
    drain();

    summary();
    $finish;
  end
endmodule